// File: doc/BRIEF.md
# SDRAM Bank State and Command Timing Checker

This block sits beside an SDRAM command bus and watches it. On every rising clock edge it samples chip select, the three strobes, clock enable, the bank address and address bit 10. It decodes the command, follows the open or idle state of each of the four banks, and measures the distance in clock cycles between related commands. When a command breaks a protocol or spacing rule, it raises a one-cycle violation flag. The flag carries a rule number and the bank involved.

Every spacing limit is a parameter expressed in clock cycles. A system integrator converts the memory's nanosecond minima by dividing each by the clock period and rounding up. The block only observes: it never drives the bus, and a violating command still updates the tracked bank state as the memory would. All outputs are registered. The decoded command, violation fields and bank state for a command sampled at edge k appear just after edge k.

Top module: `sdr_bank_checker`

## Requirements
- R1: The command is decoded from the strobes {ras_n, cas_n, we_n} when cs_n is low, and presented on cmd_o. The mappings are: 000 gives 2 (mode set), 001 gives 3 or 4 (refresh, see R2), 011 gives 5 (activate), 101 gives 6 (read), 100 gives 7 (write), 110 gives 8 (burst stop), 010 gives 9 (bank precharge, a10 low) or 10 (precharge all, a10 high), and 111 gives 1 (no-op). cs_n high gives 0 (deselect).
- R2: If cke was low on the previous sampled edge, the command is 11 (suspended) and no rule or state change applies. A refresh with cke high on both edges is 3 (auto refresh). A refresh with cke going high to low is 4 (self-refresh entry).
- R3: bank_open_o[i] rises after an activate to bank i. It falls after a precharge to bank i or a precharge all. A precharge of an idle bank has no effect and is not checked.
- R4: Rule 1. Any command other than deselect, no-op or suspended is flagged when it comes fewer than T_MRD cycles after a mode set. The reported bank is ba.
- R5: Rule 2. A mode set, auto refresh or self-refresh entry is flagged while any bank is open. The reported bank is the lowest open bank.
- R6: Rule 3. A read or write to an idle bank, or an activate to an open bank, is flagged.
- R7: Rule 4. An activate fewer than T_RRD cycles after the previous activate to any bank is flagged.
- R8: Rule 5. A read or write fewer than T_RCD cycles after the activate of its bank is flagged.
- R9: Rule 6. A precharge (single or all) of an open bank fewer than T_RAS cycles after that bank's activate is flagged. For precharge all, the lowest violating bank is reported.
- R10: Rule 7 is raised by an activate to an idle bank fewer than T_RP cycles after that bank closed. Rule 8 is raised by an activate fewer than T_RC cycles after the previous activate of the same bank.
- R11: Rule 9. A precharge of an open bank fewer than BURST_LEN-1+T_WR cycles after a write to it is flagged.
- R12: A read at cycle t with a10 high closes its bank at cycle t+BURST_LEN. A write at cycle t with a10 high closes its bank at cycle t+BURST_LEN-1+T_WR, which counts as a precharge for R10. BURST_LEN is at least 2. A read or write to that bank while the close is pending raises rule 10.
- R13: viol_o is high for exactly the cycle that reports one command. When several rules apply, the lowest rule number wins. viol_rule_o holds the rule number 1 to 10 and viol_bank_o the bank. Without a violation, both fields are 0. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Precharge-all / auto-precharge select |
| cmd_o | output | 4 | Decoded command code |
| bank_open_o | output | 4 | Per-bank open flag |
| viol_o | output | 1 | Violation pulse |
| viol_rule_o | output | 4 | Violated rule number |
| viol_bank_o | output | 2 | Bank of the violation |

## Verification
Several properties are checked on every cycle:
- the rule field and the pulse stay consistent;
- a violation is only ever attached to a real command;
- a precharge all leaves every bank idle;
- an activate leaves its bank open;
- a read or write to a bank that was idle always raises a flag.

Only the bench scenarios can show that each spacing limit fires at exactly the right cycle distance and that the priority between rules picks the lowest number. The same holds for the auto-precharge close landing on the intended cycle and for the clock-enable cases. The bench's cycle model compares every output on every clock.

// File: rtl/sdr_chk_pkg.sv
package sdr_chk_pkg;

    localparam int BANKS = 4;
    localparam int BA_W  = $clog2(BANKS);

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_MRS   = 4'd2,
        CMD_AREF  = 4'd3,
        CMD_SREF  = 4'd4,
        CMD_ACT   = 4'd5,
        CMD_RD    = 4'd6,
        CMD_WR    = 4'd7,
        CMD_BST   = 4'd8,
        CMD_PRE   = 4'd9,
        CMD_PREA  = 4'd10,
        CMD_SUSP  = 4'd11
    } cmd_e;

    typedef enum logic [3:0] {
        RULE_NONE    = 4'd0,
        RULE_MRD     = 4'd1,
        RULE_ALLIDLE = 4'd2,
        RULE_STATE   = 4'd3,
        RULE_RRD     = 4'd4,
        RULE_RCD     = 4'd5,
        RULE_RAS     = 4'd6,
        RULE_RP      = 4'd7,
        RULE_RC      = 4'd8,
        RULE_WR      = 4'd9,
        RULE_APBUSY  = 4'd10
    } rule_e;

    // Per-bank rule hits, one bit per bank-scoped rule
    typedef struct packed {
        logic state;
        logic rcd;
        logic ras;
        logic rp;
        logic rc;
        logic wr;
        logic apbusy;
    } bank_flags_t;

    function automatic cmd_e decode_cmd(input logic cke_prev, input logic cke,
                                        input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n,
                                        input logic a10);
        cmd_e c;
        if (!cke_prev)   c = CMD_SUSP;
        else if (cs_n)   c = CMD_DESEL;
        else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  c = CMD_MRS;
                3'b001:  c = cke ? CMD_AREF : CMD_SREF;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b110:  c = CMD_BST;
                3'b010:  c = a10 ? CMD_PREA : CMD_PRE;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_real_cmd(input cmd_e c);
        return !(c == CMD_DESEL || c == CMD_NOP || c == CMD_SUSP);
    endfunction

    function automatic logic needs_all_idle(input cmd_e c);
        return (c == CMD_MRS || c == CMD_AREF || c == CMD_SREF);
    endfunction

    function automatic logic [BA_W-1:0] lowest_set(input logic [BANKS-1:0] v);
        logic [BA_W-1:0] r;
        r = '0;
        for (int i = BANKS - 1; i >= 0; i--) begin
            if (v[i]) r = BA_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
    import sdr_chk_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 9,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4,
    parameter int AGE_W     = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  cmd_e        cmd,
    input  logic        sel,
    input  logic        ap,
    output logic        is_open,
    output bank_flags_t flags
);

    localparam int WR_LIM = BURST_LEN - 1 + T_WR;
    localparam logic [AGE_W-1:0] AGE_SAT = '1;
    // countdown loads so that the bank reads idle exactly at the close cycle
    localparam logic [AGE_W-1:0] AP_RD = AGE_W'(BURST_LEN - 1);
    localparam logic [AGE_W-1:0] AP_WR = AGE_W'(BURST_LEN - 2 + T_WR);

    logic [AGE_W-1:0] act_age, pre_age, wr_age, ap_wait;
    logic act_hit, rdwr_hit, pre_hit;

    function automatic logic [AGE_W-1:0] age_inc(input logic [AGE_W-1:0] v);
        return (v == AGE_SAT) ? v : v + AGE_W'(1);
    endfunction

    always_comb begin
        act_hit  = (cmd == CMD_ACT) && sel;
        rdwr_hit = (cmd == CMD_RD || cmd == CMD_WR) && sel;
        pre_hit  = ((cmd == CMD_PRE) && sel) || (cmd == CMD_PREA);

        flags.state  = (act_hit && is_open) || (rdwr_hit && !is_open);
        flags.rcd    = rdwr_hit && (int'(act_age) < T_RCD);
        flags.apbusy = rdwr_hit && is_open && (ap_wait != '0);
        flags.ras    = pre_hit && is_open && (int'(act_age) < T_RAS);
        flags.wr     = pre_hit && is_open && (int'(wr_age) < WR_LIM);
        flags.rp     = act_hit && !is_open && (int'(pre_age) < T_RP);
        flags.rc     = act_hit && (int'(act_age) < T_RC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            act_age <= AGE_SAT;
            pre_age <= AGE_SAT;
            wr_age  <= AGE_SAT;
            ap_wait <= '0;
        end else begin
            act_age <= age_inc(act_age);
            pre_age <= age_inc(pre_age);
            wr_age  <= age_inc(wr_age);
            if (act_hit) begin
                is_open <= 1'b1;
                act_age <= AGE_W'(1);
                ap_wait <= '0;
            end else if (pre_hit && is_open) begin
                is_open <= 1'b0;
                pre_age <= AGE_W'(1);
                ap_wait <= '0;
            end else begin
                if (rdwr_hit && is_open) begin
                    if (cmd == CMD_WR) wr_age <= AGE_W'(1);
                    if (ap && ap_wait == '0) ap_wait <= (cmd == CMD_WR) ? AP_WR : AP_RD;
                end
                if (ap_wait == AGE_W'(1)) begin
                    is_open <= 1'b0;
                    pre_age <= '0;
                    ap_wait <= '0;
                end else if (ap_wait != '0) begin
                    ap_wait <= ap_wait - AGE_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sdr_rule_arbiter.sv
module sdr_rule_arbiter
    import sdr_chk_pkg::*;
(
    input  logic            mrd_hit,
    input  logic            allidle_hit,
    input  logic [BA_W-1:0] idle_bank,
    input  logic            rrd_hit,
    input  logic [BA_W-1:0] cmd_bank,
    input  bank_flags_t     flags [BANKS],
    output rule_e           rule,
    output logic [BA_W-1:0] bank
);

    logic [BANKS-1:0] v_state, v_rcd, v_ras, v_rp, v_rc, v_wr, v_ap;

    for (genvar g = 0; g < BANKS; g++) begin : g_vec
        assign v_state[g] = flags[g].state;
        assign v_rcd[g]   = flags[g].rcd;
        assign v_ras[g]   = flags[g].ras;
        assign v_rp[g]    = flags[g].rp;
        assign v_rc[g]    = flags[g].rc;
        assign v_wr[g]    = flags[g].wr;
        assign v_ap[g]    = flags[g].apbusy;
    end

    // lowest rule number first, then lowest bank
    always_comb begin
        rule = RULE_NONE;
        bank = '0;
        if (mrd_hit) begin
            rule = RULE_MRD;     bank = cmd_bank;
        end else if (allidle_hit) begin
            rule = RULE_ALLIDLE; bank = idle_bank;
        end else if (|v_state) begin
            rule = RULE_STATE;   bank = lowest_set(v_state);
        end else if (rrd_hit) begin
            rule = RULE_RRD;     bank = cmd_bank;
        end else if (|v_rcd) begin
            rule = RULE_RCD;     bank = lowest_set(v_rcd);
        end else if (|v_ras) begin
            rule = RULE_RAS;     bank = lowest_set(v_ras);
        end else if (|v_rp) begin
            rule = RULE_RP;      bank = lowest_set(v_rp);
        end else if (|v_rc) begin
            rule = RULE_RC;      bank = lowest_set(v_rc);
        end else if (|v_wr) begin
            rule = RULE_WR;      bank = lowest_set(v_wr);
        end else if (|v_ap) begin
            rule = RULE_APBUSY;  bank = lowest_set(v_ap);
        end
    end

endmodule

// File: rtl/sdr_bank_checker.sv
module sdr_bank_checker
    import sdr_chk_pkg::*;
#(
    parameter int T_MRD     = 2,
    parameter int T_RRD     = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 9,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4,
    parameter int AGE_W     = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic [3:0]      cmd_o,
    output logic [BANKS-1:0] bank_open_o,
    output logic            viol_o,
    output logic [3:0]      viol_rule_o,
    output logic [BA_W-1:0] viol_bank_o
);

    localparam logic [AGE_W-1:0] AGE_SAT = '1;

    logic             cke_prev;
    cmd_e             cmd;
    logic [AGE_W-1:0] mrs_age, rrd_age;
    logic             mrd_hit, allidle_hit, rrd_hit;
    logic [BANKS-1:0] open_v;
    bank_flags_t      bflags [BANKS];
    rule_e            rule;
    logic [BA_W-1:0]  rbank;

    always_comb begin
        cmd         = decode_cmd(cke_prev, cke, cs_n, ras_n, cas_n, we_n, a10);
        mrd_hit     = is_real_cmd(cmd) && (int'(mrs_age) < T_MRD);
        allidle_hit = needs_all_idle(cmd) && (|open_v);
        rrd_hit     = (cmd == CMD_ACT) && (int'(rrd_age) < T_RRD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_prev <= 1'b1;
            mrs_age  <= AGE_SAT;
            rrd_age  <= AGE_SAT;
        end else begin
            cke_prev <= cke;
            mrs_age  <= (mrs_age == AGE_SAT) ? mrs_age : mrs_age + AGE_W'(1);
            rrd_age  <= (rrd_age == AGE_SAT) ? rrd_age : rrd_age + AGE_W'(1);
            if (cmd == CMD_MRS) mrs_age <= AGE_W'(1);
            if (cmd == CMD_ACT) rrd_age <= AGE_W'(1);
        end
    end

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        sdr_bank_track #(
            .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
            .T_WR(T_WR), .BURST_LEN(BURST_LEN), .AGE_W(AGE_W)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .cmd     (cmd),
            .sel     (ba == BA_W'(g)),
            .ap      (a10),
            .is_open (open_v[g]),
            .flags   (bflags[g])
        );
    end

    sdr_rule_arbiter u_arb (
        .mrd_hit     (mrd_hit),
        .allidle_hit (allidle_hit),
        .idle_bank   (lowest_set(open_v)),
        .rrd_hit     (rrd_hit),
        .cmd_bank    (ba),
        .flags       (bflags),
        .rule        (rule),
        .bank        (rbank)
    );

    assign bank_open_o = open_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o       <= '0;
            viol_o      <= 1'b0;
            viol_rule_o <= '0;
            viol_bank_o <= '0;
        end else begin
            cmd_o       <= cmd;
            viol_o      <= (rule != RULE_NONE);
            viol_rule_o <= rule;
            viol_bank_o <= (rule != RULE_NONE) ? rbank : '0;
        end
    end

endmodule

// File: rtl/sdr_bank_checker_sva.sv
module sdr_bank_checker_sva
    import sdr_chk_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [BA_W-1:0] ba,
    input logic [3:0]      cmd_o,
    input logic [BANKS-1:0] bank_open_o,
    input logic            viol_o,
    input logic [3:0]      viol_rule_o,
    input logic [BA_W-1:0] viol_bank_o
);

    a_r13_rule_when_flagged: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (viol_rule_o != 4'd0 && viol_rule_o <= 4'd10));

    a_r13_quiet_fields: assert property (@(posedge clk) disable iff (rst)
        !viol_o |-> (viol_rule_o == 4'd0 && viol_bank_o == '0));

    a_r13_real_command_only: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> !(cmd_o == 4'd0 || cmd_o == 4'd1 || cmd_o == 4'd11));

    a_r3_prea_closes_all: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'd10) |-> (bank_open_o == '0));

    a_r3_act_opens_bank: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'd5) |-> bank_open_o[$past(ba)]);

    a_r6_access_idle_flagged: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == 4'd6 || cmd_o == 4'd7) && !$past(bank_open_o[ba])) |-> viol_o);

endmodule

bind sdr_bank_checker sdr_bank_checker_sva u_sva (.*);

// File: tb/tb_sdr_bank_checker.sv
module tb_sdr_bank_checker;

    localparam int T_MRD = 2, T_RRD = 2, T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9;
    localparam int T_WR = 2, BL = 4;

    localparam int C_DESEL = 0, C_NOP = 1, C_MRS = 2, C_AREF = 3, C_SREF = 4, C_ACT = 5;
    localparam int C_RD = 6, C_WR = 7, C_BST = 8, C_PRE = 9, C_PREA = 10, C_SUSP = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] cmd_o;
    logic [3:0] bank_open_o;
    logic       viol_o;
    logic [3:0] viol_rule_o;
    logic [1:0] viol_bank_o;

    always #2 clk = ~clk;

    sdr_bank_checker dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_open_o(bank_open_o),
        .viol_o(viol_o), .viol_rule_o(viol_rule_o), .viol_bank_o(viol_bank_o)
    );

    int n_checks = 0, n_errors = 0;

    // behavioural reference state: cycle stamps of the last events
    int cyc = 0;
    int last_act [4], pre_t [4], last_wr [4], ap_end [4];
    bit open_m [4];
    int last_mrs = -1000, last_rrd = -1000;
    bit ck_prev_m = 1'b1;
    bit ck_level = 1'b1;

    int exp_cmd = 0, exp_rule = 0, exp_bank = 0;
    bit exp_viol = 1'b0;
    logic [3:0] exp_open = 4'd0;
    string exp_tag = "R13";

    task automatic chk(input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s %s cycle %0d actual %0d expected %0d", exp_tag, what, cyc, act, expv);
        end
    endtask

    task automatic compare_all();
        chk("cmd", int'(cmd_o), exp_cmd);
        chk("viol", int'(viol_o), int'(exp_viol));
        chk("rule", int'(viol_rule_o), exp_rule);
        chk("bank", int'(viol_bank_o), exp_bank);
        chk("open", int'(bank_open_o), int'(exp_open));
    endtask

    task automatic model(input logic csn, input logic rasn, input logic casn, input logic wen,
                         input logic ck, input int b, input logic ap);
        int c, code, r, rb;
        bit any_open, real_cmd, is_pre;
        c = cyc;
        if (!ck_prev_m) code = C_SUSP;
        else if (csn) code = C_DESEL;
        else begin
            case ({rasn, casn, wen})
                3'b000: code = C_MRS;
                3'b001: code = ck ? C_AREF : C_SREF;
                3'b011: code = C_ACT;
                3'b101: code = C_RD;
                3'b100: code = C_WR;
                3'b110: code = C_BST;
                3'b010: code = ap ? C_PREA : C_PRE;
                default: code = C_NOP;
            endcase
        end
        any_open = open_m[0] | open_m[1] | open_m[2] | open_m[3];
        real_cmd = !(code == C_DESEL || code == C_NOP || code == C_SUSP);
        is_pre   = (code == C_PRE || code == C_PREA);
        r = 0; rb = 0;
        if (real_cmd && (c - last_mrs) < T_MRD) begin r = 1; rb = b; end
        else if ((code == C_MRS || code == C_AREF || code == C_SREF) && any_open) begin
            r = 2;
            for (int i = 3; i >= 0; i--) if (open_m[i]) rb = i;
        end
        else if ((code == C_ACT && open_m[b]) || ((code == C_RD || code == C_WR) && !open_m[b])) begin
            r = 3; rb = b;
        end
        else if (code == C_ACT && (c - last_rrd) < T_RRD) begin r = 4; rb = b; end
        else if ((code == C_RD || code == C_WR) && (c - last_act[b]) < T_RCD) begin r = 5; rb = b; end
        else if (code == C_ACT && (c - pre_t[b]) < T_RP) begin r = 7; rb = b; end
        else if (code == C_ACT && (c - last_act[b]) < T_RC) begin r = 8; rb = b; end
        else if ((code == C_RD || code == C_WR) && ap_end[b] >= 0) begin r = 10; rb = b; end
        else if (is_pre) begin
            for (int i = 3; i >= 0; i--)
                if ((code == C_PREA || i == b) && open_m[i] && (c - last_wr[i]) < BL - 1 + T_WR) begin
                    r = 9; rb = i;
                end
            for (int i = 3; i >= 0; i--)
                if ((code == C_PREA || i == b) && open_m[i] && (c - last_act[i]) < T_RAS) begin
                    r = 6; rb = i;
                end
        end
        // state updates
        if (code == C_MRS) last_mrs = c;
        if (code == C_ACT) begin
            last_rrd = c; open_m[b] = 1'b1; last_act[b] = c; ap_end[b] = -1;
        end
        if (is_pre)
            for (int i = 0; i < 4; i++)
                if ((code == C_PREA || i == b) && open_m[i]) begin
                    open_m[i] = 1'b0; pre_t[i] = c; ap_end[i] = -1;
                end
        if ((code == C_RD || code == C_WR) && open_m[b]) begin
            if (code == C_WR) last_wr[b] = c;
            if (ap && ap_end[b] < 0) ap_end[b] = c + ((code == C_WR) ? (BL - 1 + T_WR) : BL);
        end
        for (int i = 0; i < 4; i++)
            if (ap_end[i] >= 0 && ap_end[i] <= c + 1) begin
                open_m[i] = 1'b0; pre_t[i] = ap_end[i]; ap_end[i] = -1;
            end
        ck_prev_m = ck;
        exp_cmd = code; exp_rule = r; exp_viol = (r != 0); exp_bank = (r != 0) ? rb : 0;
        for (int i = 0; i < 4; i++) exp_open[i] = open_m[i];
    endtask

    task automatic drive(input logic csn, input logic rasn, input logic casn, input logic wen,
                         input int b, input logic ap, input string tag);
        @(negedge clk);
        compare_all();
        rst = 1'b0;
        cs_n = csn; ras_n = rasn; cas_n = casn; we_n = wen; cke = ck_level;
        ba = 2'(b); a10 = ap;
        model(csn, rasn, casn, wen, ck_level, b, ap);
        exp_tag = tag;
        cyc++;
    endtask

    task automatic nop(input string tag);            drive(0, 1, 1, 1, 0, 0, tag); endtask
    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) nop(tag);
    endtask
    task automatic desel(input string tag);          drive(1, 1, 1, 1, 0, 0, tag); endtask
    task automatic mrs(input string tag);            drive(0, 0, 0, 0, 0, 0, tag); endtask
    task automatic refr(input string tag);           drive(0, 0, 0, 1, 0, 0, tag); endtask
    task automatic act(input int b, input string tag);  drive(0, 0, 1, 1, b, 0, tag); endtask
    task automatic rd(input int b, input logic ap, input string tag); drive(0, 1, 0, 1, b, ap, tag); endtask
    task automatic wr(input int b, input logic ap, input string tag); drive(0, 1, 0, 0, b, ap, tag); endtask
    task automatic bst(input string tag);            drive(0, 1, 1, 0, 0, 0, tag); endtask
    task automatic pre(input int b, input string tag);  drive(0, 0, 1, 0, b, 0, tag); endtask
    task automatic prea(input string tag);           drive(0, 0, 1, 0, 0, 1, tag); endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL R13 watchdog actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            last_act[i] = -1000; pre_t[i] = -1000; last_wr[i] = -1000; ap_end[i] = -1; open_m[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // first compare sees the reset state (R13)
        nop("R13");
        desel("R1");
        bst("R1");
        nops(2, "R1");
        // mode set spacing (R4)
        mrs("R4");
        act(0, "R4");
        nops(2, "R4");
        // all-idle requirement (R5)
        mrs("R5");
        nops(2, "R5");
        refr("R5");
        // illegal state (R6)
        rd(1, 0, "R6");
        wr(2, 0, "R6");
        act(0, "R6");
        nops(3, "R9");
        pre(0, "R9");          // row active too short
        act(0, "R10");         // row precharge too short
        act(1, "R7");          // activate spacing across banks
        rd(1, 0, "R8");        // column access too early
        nops(8, "R3");
        pre(1, "R3");
        pre(3, "R3");          // idle bank, no effect
        nops(6, "R3");
        // row cycle: early precharge then re-activate after row precharge
        act(2, "R10");
        nop("R10");
        pre(2, "R9");
        nops(2, "R10");
        act(2, "R10");
        nops(6, "R11");
        wr(2, 0, "R11");
        pre(2, "R11");         // write recovery
        nops(6, "R12");
        // auto precharge write on bank 3
        act(3, "R12");
        nops(3, "R12");
        wr(3, 1, "R12");
        rd(3, 0, "R12");       // busy with pending close
        nops(3, "R12");
        act(3, "R12");         // closed, row precharge not yet met
        nops(9, "R12");
        rd(3, 1, "R12");       // auto precharge read
        nops(BL, "R12");
        act(3, "R12");
        nops(3, "R12");
        act(3, "R12");
        nops(8, "R9");
        // precharge all with one bank young
        act(1, "R9");
        prea("R9");
        nops(4, "R3");
        prea("R3");
        nops(2, "R2");
        refr("R2");            // auto refresh, all idle
        nops(2, "R2");
        ck_level = 1'b0;
        refr("R2");            // self-refresh entry
        nops(2, "R2");         // suspended
        ck_level = 1'b1;
        act(0, "R2");          // previous cke low: still suspended
        nops(2, "R1");
        pre(0, "R1");
        nops(2, "R13");
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule